// File: doc/BRIEF.md
# Prefix Relocation and Storage-Key Update

This block sits between an address translator and main storage. It turns a real address into an absolute address by exchanging two 8 KiB windows: the window at address zero and the window that starts at the CPU's prefix value. An access in the low window is moved up to the prefix area. An access in the prefix area is moved down to zero. Every other address passes through unchanged. For an access that is relocated, the block also limits the requested length so that the access ends inside the window it started in.

The block also keeps the per-page storage keys up to date. Each valid access that lands inside configured storage produces a read-modify-write of the 4 KiB page's key. The key's reference bit is set when reading is permitted, and its change bit is set when writing is permitted. The key array lives outside the block. The block drives a combinational read index, takes the current key value back, and issues one registered write. That write forwards its own data to a directly following access to the same page, so no update is lost.

Top module: `pfx_reloc_skey`

## Requirements
- R1: When real_addr is below 8192, abs_addr equals the prefix value plus real_addr, where the low 13 bits of prefix are treated as zero.
- R2: When real_addr is not below 8192 and lies between the aligned prefix and the aligned prefix + 8191, abs_addr equals real_addr minus the aligned prefix.
- R3: Any other real_addr appears unchanged on abs_addr, and max_len equals req_len.
- R4: For a relocated address, max_len is the smaller of req_len and 8192 minus real_addr[12:0].
- R5: In the clock cycle after a sampled access_valid, key_we is high and key_widx equals abs_addr[17:12]. key_wdata is the value read at that index, with the reference bit (bit 2) set if perm_rd was high and the change bit (bit 1) set if perm_wr was high. All other key bits are kept.
- R6: No key write follows an access whose abs_addr is greater than mem_size. An access with abs_addr equal to mem_size still updates its key.
- R7: An access with neither perm_rd nor perm_wr causes no key write.
- R8: When two accesses to the same page come on consecutive cycles, the second write contains the bits set by the first, even though the array has not yet taken the first write.
- R9: While reset is asserted and in the first cycle after it is released, key_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| real_addr | input | 32 | Real address of the access |
| prefix | input | 32 | Prefix value; bits 12:0 are ignored |
| req_len | input | 32 | Length of the access in bytes |
| mem_size | input | 32 | Highest absolute address that has a storage key |
| perm_rd | input | 1 | Read permitted for this access |
| perm_wr | input | 1 | Write permitted for this access |
| access_valid | input | 1 | Strobe that requests a key update for the current access |
| abs_addr | output | 32 | Absolute address after relocation |
| max_len | output | 32 | Length after clamping to the window |
| key_ridx | output | 6 | Key array read index (page of abs_addr) |
| key_rdata | input | 7 | Key value at key_ridx |
| key_we | output | 1 | Key array write enable |
| key_widx | output | 6 | Key array write index |
| key_wdata | output | 7 | Key value to write |

## Verification
Some properties are checked on every cycle: an unmoved address stays equal to its input, the low window always adds the aligned prefix, max_len never exceeds req_len, no key write appears without a strobe in the cycle before it, a key write always carries a reference or change bit, and the range and permission gates hold. The actual key values can only be shown by the bench's scenarios. These scenarios preload patterns into a model of the key array and read them back after the updates. They cover preservation of the untouched bits, the exact mem_size boundary, and the merge of two updates to one page on consecutive cycles. The same holds for the relocation results at the window edges, including a prefix next to the low window and a prefix at the top of the address space.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

   typedef enum logic [1:0] {
      WIN_PASS = 2'd0,
      WIN_LOW  = 2'd1,
      WIN_PFX  = 2'd2
   } win_e;

   function automatic logic [31:0] umin32(input logic [31:0] a, input logic [31:0] b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/pfx_window_map.sv
module pfx_window_map
   import pfx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int WIN_BITS = 13
) (
   input  logic [ADDR_W-1:0] real_addr,
   input  logic [ADDR_W-1:0] prefix,
   input  logic [ADDR_W-1:0] req_len,
   output logic [ADDR_W-1:0] abs_addr,
   output logic [ADDR_W-1:0] max_len,
   output win_e              win
);
   localparam logic [ADDR_W-1:0] ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [ADDR_W-1:0] WIN_SIZE = ONE << WIN_BITS;
   localparam logic [ADDR_W-1:0] LO_MASK  = WIN_SIZE - ONE;
   localparam logic [ADDR_W-1:0] HI_MASK  = ~LO_MASK;

   generate
      if (WIN_BITS < 1 || WIN_BITS >= ADDR_W) begin : g_bad_win
         $error("pfx_window_map: WIN_BITS must lie in 1..ADDR_W-1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_hi;
   logic [ADDR_W-1:0] addr_off;
   logic [ADDR_W-1:0] pfx_base;
   logic [ADDR_W-1:0] room;
   logic              lo_hit;
   logic              pfx_hit;

   always_comb begin
      addr_hi  = real_addr & HI_MASK;
      addr_off = real_addr & LO_MASK;
      pfx_base = prefix & HI_MASK;
      room     = WIN_SIZE - addr_off;
      lo_hit   = (addr_hi == '0);
      pfx_hit  = !lo_hit && (addr_hi == pfx_base);
   end

   always_comb begin
      abs_addr = real_addr;
      max_len  = req_len;
      win      = WIN_PASS;
      if (lo_hit) begin
         win      = WIN_LOW;
         abs_addr = pfx_base | addr_off;
         max_len  = (req_len < room) ? req_len : room;
      end else if (pfx_hit) begin
         win      = WIN_PFX;
         abs_addr = addr_off;
         max_len  = (req_len < room) ? req_len : room;
      end
   end

endmodule

// File: rtl/skey_update.sv
module skey_update #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter int IDX_W     = 6,
   parameter int KEY_W     = 7,
   parameter int REF_POS   = 2,
   parameter int CHG_POS   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access_valid,
   input  logic [ADDR_W-1:0] abs_addr,
   input  logic [ADDR_W-1:0] mem_size,
   input  logic              perm_rd,
   input  logic              perm_wr,
   output logic [IDX_W-1:0]  key_ridx,
   input  logic [KEY_W-1:0]  key_rdata,
   output logic              key_we,
   output logic [IDX_W-1:0]  key_widx,
   output logic [KEY_W-1:0]  key_wdata
);
   generate
      if (PAGE_BITS + IDX_W > ADDR_W) begin : g_bad_idx
         $error("skey_update: page index exceeds address width");
      end
      if (REF_POS == CHG_POS || REF_POS >= KEY_W || CHG_POS >= KEY_W) begin : g_bad_bits
         $error("skey_update: reference/change bit positions invalid");
      end
   endgenerate

   logic              in_range;
   logic              do_upd;
   logic              fwd_hit;
   logic [KEY_W-1:0]  old_key;
   logic [KEY_W-1:0]  set_mask;
   logic [KEY_W-1:0]  new_key;

   assign key_ridx = abs_addr[PAGE_BITS +: IDX_W];

   always_comb begin
      in_range = (abs_addr <= mem_size);
      do_upd   = access_valid && in_range && (perm_rd || perm_wr);
      fwd_hit  = key_we && (key_widx == key_ridx);
      old_key  = fwd_hit ? key_wdata : key_rdata;
      set_mask = '0;
      set_mask[REF_POS] = perm_rd;
      set_mask[CHG_POS] = perm_wr;
      new_key  = old_key | set_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_we    <= 1'b0;
         key_widx  <= '0;
         key_wdata <= '0;
      end else begin
         key_we <= do_upd;
         if (do_upd) begin
            key_widx  <= key_ridx;
            key_wdata <= new_key;
         end
      end
   end

   // R5
   wr_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_we |-> $past(access_valid));

   // R5
   wr_marks_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_we |-> (key_wdata[REF_POS] || key_wdata[CHG_POS]));

   // R6
   range_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access_valid && (abs_addr > mem_size)) |=> !key_we);

   // R7
   no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access_valid && !perm_rd && !perm_wr) |=> !key_we);

   // R8
   merge_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_upd && key_we && (key_widx == key_ridx))
      |=> ((key_wdata & $past(key_wdata)) == $past(key_wdata)));

endmodule

// File: rtl/pfx_reloc_skey.sv
module pfx_reloc_skey
   import pfx_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int WIN_BITS  = 13,
   parameter int PAGE_BITS = 12,
   parameter int IDX_W     = 6,
   parameter int KEY_W     = 7,
   parameter int REF_POS   = 2,
   parameter int CHG_POS   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] real_addr,
   input  logic [ADDR_W-1:0] prefix,
   input  logic [ADDR_W-1:0] req_len,
   input  logic [ADDR_W-1:0] mem_size,
   input  logic              perm_rd,
   input  logic              perm_wr,
   input  logic              access_valid,
   output logic [ADDR_W-1:0] abs_addr,
   output logic [ADDR_W-1:0] max_len,
   output logic [IDX_W-1:0]  key_ridx,
   input  logic [KEY_W-1:0]  key_rdata,
   output logic              key_we,
   output logic [IDX_W-1:0]  key_widx,
   output logic [KEY_W-1:0]  key_wdata
);
   localparam logic [ADDR_W-1:0] HI_MASK = ~(({{(ADDR_W-1){1'b0}}, 1'b1} << WIN_BITS)
                                             - {{(ADDR_W-1){1'b0}}, 1'b1});

   generate
      if (PAGE_BITS > WIN_BITS) begin : g_bad_page
         $error("pfx_reloc_skey: page must not be larger than the window");
      end
   endgenerate

   win_e win;

   pfx_window_map #(
      .ADDR_W   (ADDR_W),
      .WIN_BITS (WIN_BITS)
   ) u_map (
      .real_addr (real_addr),
      .prefix    (prefix),
      .req_len   (req_len),
      .abs_addr  (abs_addr),
      .max_len   (max_len),
      .win       (win)
   );

   skey_update #(
      .ADDR_W    (ADDR_W),
      .PAGE_BITS (PAGE_BITS),
      .IDX_W     (IDX_W),
      .KEY_W     (KEY_W),
      .REF_POS   (REF_POS),
      .CHG_POS   (CHG_POS)
   ) u_key (
      .clk          (clk),
      .rst_n        (rst_n),
      .access_valid (access_valid),
      .abs_addr     (abs_addr),
      .mem_size     (mem_size),
      .perm_rd      (perm_rd),
      .perm_wr      (perm_wr),
      .key_ridx     (key_ridx),
      .key_rdata    (key_rdata),
      .key_we       (key_we),
      .key_widx     (key_widx),
      .key_wdata    (key_wdata)
   );

   // R1
   low_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((real_addr & HI_MASK) == '0) |-> ((abs_addr - real_addr) == (prefix & HI_MASK)));

   // R3
   pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win == WIN_PASS) |-> ((abs_addr == real_addr) && (max_len == req_len)));

   // R4
   len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      max_len <= req_len);

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !key_we);

endmodule

// File: tb/sim_pfx_reloc_skey.sv
module sim_pfx_reloc_skey;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] real_addr = '0;
   logic [31:0] prefix = '0;
   logic [31:0] req_len = '0;
   logic [31:0] mem_size = 32'h0003_FFFF;
   logic        perm_rd = 1'b0;
   logic        perm_wr = 1'b0;
   logic        access_valid = 1'b0;
   logic [31:0] abs_addr;
   logic [31:0] max_len;
   logic [5:0]  key_ridx;
   logic [6:0]  key_rdata;
   logic        key_we;
   logic [5:0]  key_widx;
   logic [6:0]  key_wdata;

   logic [6:0]  keys [64];

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign key_rdata = keys[key_ridx];

   always @(posedge clk) begin
      if (key_we) keys[key_widx] <= key_wdata;
   end

   pfx_reloc_skey u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .real_addr    (real_addr),
      .prefix       (prefix),
      .req_len      (req_len),
      .mem_size     (mem_size),
      .perm_rd      (perm_rd),
      .perm_wr      (perm_wr),
      .access_valid (access_valid),
      .abs_addr     (abs_addr),
      .max_len      (max_len),
      .key_ridx     (key_ridx),
      .key_rdata    (key_rdata),
      .key_we       (key_we),
      .key_widx     (key_widx),
      .key_wdata    (key_wdata)
   );

   // prefix, real_addr, req_len, expected abs_addr, expected max_len
   localparam int NV = 11;
   localparam logic [159:0] VEC [NV] = '{
      {32'h0002_0000, 32'h0000_0100, 32'h0000_0100, 32'h0002_0100, 32'h0000_0100},
      {32'h0002_0000, 32'h0000_1F80, 32'h0000_0200, 32'h0002_1F80, 32'h0000_0080},
      {32'h0002_0000, 32'h0002_1000, 32'h0000_2000, 32'h0000_1000, 32'h0000_1000},
      {32'h0002_0000, 32'h0002_1FFF, 32'h0000_0010, 32'h0000_1FFF, 32'h0000_0001},
      {32'h0002_0000, 32'h0002_2000, 32'h0000_3000, 32'h0002_2000, 32'h0000_3000},
      {32'h0002_0000, 32'h0001_FFFF, 32'h0000_0040, 32'h0001_FFFF, 32'h0000_0040},
      {32'h0002_1FFF, 32'h0000_0000, 32'h0000_4000, 32'h0002_0000, 32'h0000_2000},
      {32'h0000_2000, 32'h0000_2000, 32'h0000_0008, 32'h0000_0000, 32'h0000_0008},
      {32'h0000_2000, 32'h0000_1FFF, 32'h0000_0010, 32'h0000_3FFF, 32'h0000_0001},
      {32'hFFFF_E000, 32'hFFFF_F000, 32'h0000_2000, 32'h0000_1000, 32'h0000_1000},
      {32'hFFFF_E000, 32'h0000_0010, 32'h0000_0000, 32'hFFFF_E010, 32'h0000_0000}
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic set_acc(input logic [31:0] a, input logic rd, input logic wr, input logic v);
      real_addr    = a;
      perm_rd      = rd;
      perm_wr      = wr;
      access_valid = v;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) keys[i] = 7'h00;
      keys[5]  = 7'h51;
      keys[32] = 7'h40;
      keys[7]  = 7'h10;
      keys[48] = 7'h68;
      keys[20] = 7'h33;

      // R9: quiet during reset
      repeat (3) @(negedge clk);
      chk("R9 reset key_we", {31'b0, key_we}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 after reset key_we", {31'b0, key_we}, 32'h0);

      // R1 R2 R3 R4: vector table
      for (int i = 0; i < NV; i++) begin
         prefix    = VEC[i][159:128];
         real_addr = VEC[i][127:96];
         req_len   = VEC[i][95:64];
         #2;
         chk($sformatf("R1/R2/R3 abs_addr vec%0d", i), abs_addr, VEC[i][63:32]);
         chk($sformatf("R4/R3 max_len vec%0d", i), max_len, VEC[i][31:0]);
         @(negedge clk);
      end

      prefix   = 32'h0002_0000;
      req_len  = 32'h0000_0008;
      mem_size = 32'h0003_FFFF;

      // R5: read-only access, page 5 passes through; 0x51 | ref -> 0x55
      @(negedge clk); set_acc(32'h0000_5000, 1'b1, 1'b0, 1'b1);
      @(negedge clk); access_valid = 1'b0;
      chk("R5 rd we", {31'b0, key_we}, 32'h1);
      chk("R5 rd widx", {26'b0, key_widx}, 32'd5);
      chk("R5 rd wdata", {25'b0, key_wdata}, 32'h55);
      @(negedge clk);
      chk("R5 rd array", {25'b0, keys[5]}, 32'h55);

      // R1 R5: low window to page 32 with rd+wr; 0x40 -> 0x46
      set_acc(32'h0000_0100, 1'b1, 1'b1, 1'b1);
      @(negedge clk); access_valid = 1'b0;
      chk("R1 R5 rdwr widx", {26'b0, key_widx}, 32'd32);
      chk("R5 rdwr wdata", {25'b0, key_wdata}, 32'h46);

      // R2 R5: prefix window to page 1, write only; 0x00 -> 0x02
      @(negedge clk); set_acc(32'h0002_1000, 1'b0, 1'b1, 1'b1);
      @(negedge clk); access_valid = 1'b0;
      chk("R2 R5 wr widx", {26'b0, key_widx}, 32'd1);
      chk("R5 wr wdata", {25'b0, key_wdata}, 32'h02);

      // R7: no permission, page 20 must stay 0x33
      @(negedge clk); set_acc(32'h0001_4000, 1'b0, 1'b0, 1'b1);
      @(negedge clk); access_valid = 1'b0;
      chk("R7 no-perm we", {31'b0, key_we}, 32'h0);
      @(negedge clk);
      chk("R7 no-perm array", {25'b0, keys[20]}, 32'h33);

      // R6: above mem_size -> no write
      mem_size = 32'h0001_FFFF;
      set_acc(32'h0003_0000, 1'b1, 1'b1, 1'b1);
      @(negedge clk); access_valid = 1'b0;
      chk("R6 above size we", {31'b0, key_we}, 32'h0);
      @(negedge clk);
      chk("R6 above size array", {25'b0, keys[48]}, 32'h68);

      // R6: exactly mem_size -> write, 0x68 | ref -> 0x6C
      mem_size = 32'h0003_0000;
      set_acc(32'h0003_0000, 1'b1, 1'b0, 1'b1);
      @(negedge clk); access_valid = 1'b0;
      chk("R6 at size we", {31'b0, key_we}, 32'h1);
      chk("R6 at size wdata", {25'b0, key_wdata}, 32'h6C);
      mem_size = 32'h0003_FFFF;

      // R8: back-to-back to page 7: rd then wr; 0x10 -> 0x14 -> 0x16
      @(negedge clk); set_acc(32'h0000_7000, 1'b1, 1'b0, 1'b1);
      @(negedge clk); set_acc(32'h0000_7800, 1'b0, 1'b1, 1'b1);
      chk("R8 first wdata", {25'b0, key_wdata}, 32'h14);
      @(negedge clk); access_valid = 1'b0;
      chk("R8 second we", {31'b0, key_we}, 32'h1);
      chk("R8 merged wdata", {25'b0, key_wdata}, 32'h16);
      @(negedge clk);
      chk("R8 array", {25'b0, keys[7]}, 32'h16);
      chk("R5 idle we", {31'b0, key_we}, 32'h0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog got=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule